// File: doc/BRIEF.md
# Configurable LUT Logic Slice

A behavioural model of one programmable-fabric slice. The slice has two 4-input function generators. Each generator is a 16-entry truth table. A mode field switches a generator between three uses: a fixed truth table, a 16x1 RAM with synchronous write and asynchronous read, or a 16-bit shift register whose tap is chosen by the four inputs. Every generator also has a dedicated carry stage, so the pair forms two bits of a ripple adder. A combining mux, steered by an extra select input, can merge the two generators into a single 5-input function.

Each of the two output paths ends in a storage element. That element is either an edge-triggered flip-flop or a level-sensitive latch, and it has a clock enable. A per-path configuration bit chooses whether the path output comes from the combinational result or from the storage element.

All control bits and all table contents are loaded through one serial chain, one bit per clock, while `prog_en` is high. While loading is in progress every output is held at 0.

Top module: `lut_slice`

## Requirements
- R1: While `prog_en` is high, the 43-bit configuration word shifts in through `cfg_in` at one bit per clock, bit 0 first. After 43 clocks the word is placed as follows:
  - bit 0 is the combine bit;
  - bits 21:1 are generator A's segment;
  - bits 42:22 are generator B's segment.
  
  Each segment has the layout {arith, latch, reg_sel, mode[1:0], table[15:0]}. While `prog_en` is low, no control bit changes, and the table changes only through R4 and R5.
- R2: While `prog_en` is high, `comb_o`, `q_o`, `out_o` and `carry_out` are all 0. RAM writes, shifts and storage updates are suppressed.
- R3: In truth mode (mode 0 or 3), the generator output is `table[addr]`, where `addr` is `ina` for A and `inb` for B.
- R4: In RAM mode (mode 1), a clock edge with `we` high writes `din[g]` to `table[addr]`. The read is asynchronous. With `we` low, the table is not changed.
- R5: In shift mode (mode 2), a clock edge with `we` high shifts the table up one place and loads `din[g]` into position 0. The output is the tap at `addr`, and tap 0 is the newest bit. With `we` low, there is no shift.
- R6: Each generator computes carry = lut ? cin : addr[0]. Its result is lut XOR cin when its arith bit is set, and lut otherwise. A takes `carry_in`, B takes A's carry, and `carry_out` is B's carry. With both tables set to 16'h6666, the slice adds two 2-bit numbers.
- R7: With the combine bit set, path 1's combinational result is B's LUT output when `sel5` is 1 and A's LUT output when `sel5` is 0.
- R8: `out_o[p]` equals `q_o[p]` when the path's reg_sel bit is 1, and `comb_o[p]` when it is 0.
- R9: In flip-flop mode (latch bit 0), the storage element captures `comb_o[p]` on a rising edge with `ce` high. It holds its value when `ce` is low.
- R10: In latch mode (latch bit 1), the storage element follows `comb_o[p]` while `clk` and `ce` are high. It holds its value while `clk` is low.
- R11: A synchronous high `rst` clears both storage elements. It does not change the configuration or the table contents.
- R12: On an edge where a RAM write and a flip-flop capture on the same path coincide, the flip-flop takes the value read before the write, and the combinational output shows the new contents afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the storage elements |
| prog_en | input | 1 | Serial configuration load enable |
| cfg_in | input | 1 | Serial configuration data |
| ina | input | 4 | Generator A inputs / address / tap |
| inb | input | 4 | Generator B inputs / address / tap |
| sel5 | input | 1 | Select for the combining mux |
| din | input | 2 | RAM / shift data, bit g for generator g |
| carry_in | input | 1 | Carry into generator A |
| ce | input | 1 | Clock enable of both storage elements |
| we | input | 1 | RAM write / shift enable |
| comb_o | output | 2 | Combinational result per path |
| q_o | output | 2 | Storage element output per path |
| out_o | output | 2 | Selected path output |
| carry_out | output | 1 | Carry out of generator B |

## Verification
The case that needs the most care is a RAM write and a flip-flop capture on the same clock edge. Both act on the same table location, and the captured value must be the word read before the write. The bench provokes this by driving the write, with `din` set to the inverse of the stored bit, while `ce` is high. Half a cycle after the edge it checks two things: `q_o` must hold the old bit, and `comb_o` must show the inverted bit. The other coincidence is a programming load running while `we` and `ce` toggle at random. This is judged by the outputs staying at 0 during the load and by the table contents matching the loaded word afterwards.

// File: rtl/slice_pkg.sv
package slice_pkg;
   // Generator mode field values
   typedef enum logic [1:0] {
      FG_TRUTH  = 2'd0,
      FG_RAM    = 2'd1,
      FG_SHIFT  = 2'd2,
      FG_TRUTH2 = 2'd3
   } fg_mode_e;

   // Control field offsets, counted above the table bits of a segment
   localparam int CTL_W   = 5;
   localparam int OFS_MOD = 0;
   localparam int OFS_REG = 2;
   localparam int OFS_LAT = 3;
   localparam int OFS_ARI = 4;
endpackage

// File: rtl/slice_fgen.sv
module slice_fgen
   import slice_pkg::*;
#(
   parameter int LUT_IN = 4
) (
   input  logic                     clk,
   input  logic                     prog_en,
   input  logic                     ser_in,
   output logic                     ser_out,
   input  logic [LUT_IN-1:0]        addr,
   input  logic                     din,
   input  logic                     we,
   input  logic                     carry_in,
   output logic                     lut_o,
   output logic                     res_o,
   output logic                     carry_o,
   output logic [(1<<LUT_IN)-1:0]   content_o,
   output logic [1:0]               mode_o,
   output logic                     reg_sel_o,
   output logic                     latch_o
);
   localparam int DEPTH = 1 << LUT_IN;
   localparam int SEG_W = DEPTH + CTL_W;

   logic [SEG_W-1:0] seg_q;
   logic [DEPTH-1:0] table_w;
   logic [DEPTH-1:0] table_nxt;
   fg_mode_e         mode;
   logic             arith;

   assign table_w = seg_q[DEPTH-1:0];
   assign mode    = fg_mode_e'(seg_q[DEPTH+OFS_MOD +: 2]);
   assign arith   = seg_q[DEPTH+OFS_ARI];

   // Next table contents for the writable modes
   always_comb begin
      table_nxt = table_w;
      if (we) begin
         case (mode)
            FG_RAM:   table_nxt[addr] = din;
            FG_SHIFT: table_nxt = {table_w[DEPTH-2:0], din};
            default:  table_nxt = table_w;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (prog_en) begin
         seg_q <= {ser_in, seg_q[SEG_W-1:1]};
      end else begin
         seg_q[DEPTH-1:0] <= table_nxt;
      end
   end

   // Lookup, propagate term and dedicated carry
   assign lut_o   = table_w[addr];
   assign carry_o = lut_o ? carry_in : addr[0];
   assign res_o   = arith ? (lut_o ^ carry_in) : lut_o;

   assign ser_out   = seg_q[0];
   assign content_o = table_w;
   assign mode_o    = seg_q[DEPTH+OFS_MOD +: 2];
   assign reg_sel_o = seg_q[DEPTH+OFS_REG];
   assign latch_o   = seg_q[DEPTH+OFS_LAT];
endmodule

// File: rtl/slice_store.sv
module slice_store #(
   parameter bit HAS_LATCH = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic d,
   input  logic latch_mode,
   output logic q
);
   logic ff_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ff_q <= 1'b0;
      end else if (en) begin
         ff_q <= d;
      end
   end

   generate
      if (HAS_LATCH) begin : g_latch
         logic lat_q;
         always_latch begin
            if (clk && rst) begin
               lat_q <= 1'b0;
            end else if (clk && en) begin
               lat_q <= d;
            end
         end
         assign q = latch_mode ? lat_q : ff_q;
      end else begin : g_ff_only
         logic unused_mode;
         assign unused_mode = latch_mode;
         assign q = ff_q;
      end
   endgenerate
endmodule

// File: rtl/lut_slice.sv
module lut_slice
   import slice_pkg::*;
#(
   parameter int LUT_IN    = 4,
   parameter bit HAS_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              prog_en,
   input  logic              cfg_in,
   input  logic [LUT_IN-1:0] ina,
   input  logic [LUT_IN-1:0] inb,
   input  logic              sel5,
   input  logic [1:0]        din,
   input  logic              carry_in,
   input  logic              ce,
   input  logic              we,
   output logic [1:0]        comb_o,
   output logic [1:0]        q_o,
   output logic [1:0]        out_o,
   output logic              carry_out
);
   localparam int DEPTH = 1 << LUT_IN;
   localparam int NG    = 2;
   localparam int SEG_W = DEPTH + CTL_W;
   localparam int CFG_W = NG * SEG_W + 1;

   generate
      if (LUT_IN < 2 || LUT_IN > 6) begin : g_bad_lut_in
         $error("lut_slice: LUT_IN must be 2..6");
      end
      if (CFG_W < 2 * (DEPTH + 1)) begin : g_bad_cfg
         $error("lut_slice: configuration word too short");
      end
   endgenerate

   logic [NG-1:0][LUT_IN-1:0] gen_addr;
   logic [NG-1:0]             gen_ser_in;
   logic [NG-1:0]             gen_ser_out;
   logic [NG-1:0]             gen_lut;
   logic [NG-1:0]             gen_res;
   logic [NG:0]               carry_w;
   logic [NG-1:0][DEPTH-1:0]  gen_content;
   logic [NG-1:0][1:0]        gen_mode;
   logic [NG-1:0]             gen_reg_sel;
   logic [NG-1:0]             gen_latch;
   logic                      wide_sel_q;
   logic                      f5;
   logic [NG-1:0]             path_comb;
   logic [NG-1:0]             path_q;
   logic [NG-1:0]             path_out;
   logic                      store_en;

   assign gen_addr[0] = ina;
   assign gen_addr[1] = inb;
   assign carry_w[0]  = carry_in;

   genvar g;
   generate
      for (g = 0; g < NG; g++) begin : g_gen
         if (g == NG - 1) begin : g_head
            assign gen_ser_in[g] = cfg_in;
         end else begin : g_link
            assign gen_ser_in[g] = gen_ser_out[g+1];
         end

         slice_fgen #(.LUT_IN(LUT_IN)) u_fgen (
            .clk       (clk),
            .prog_en   (prog_en),
            .ser_in    (gen_ser_in[g]),
            .ser_out   (gen_ser_out[g]),
            .addr      (gen_addr[g]),
            .din       (din[g]),
            .we        (we),
            .carry_in  (carry_w[g]),
            .lut_o     (gen_lut[g]),
            .res_o     (gen_res[g]),
            .carry_o   (carry_w[g+1]),
            .content_o (gen_content[g]),
            .mode_o    (gen_mode[g]),
            .reg_sel_o (gen_reg_sel[g]),
            .latch_o   (gen_latch[g])
         );
      end
   endgenerate

   // Tail of the configuration chain: combine-select bit
   always_ff @(posedge clk) begin
      if (prog_en) begin
         wide_sel_q <= gen_ser_out[0];
      end
   end

   assign f5           = sel5 ? gen_lut[1] : gen_lut[0];
   assign path_comb[0] = gen_res[0];
   assign path_comb[1] = wide_sel_q ? f5 : gen_res[1];
   assign store_en     = ce & ~prog_en;

   genvar p;
   generate
      for (p = 0; p < NG; p++) begin : g_path
         slice_store #(.HAS_LATCH(HAS_LATCH)) u_store (
            .clk        (clk),
            .rst        (rst),
            .en         (store_en),
            .d          (path_comb[p]),
            .latch_mode (gen_latch[p]),
            .q          (path_q[p])
         );
         assign path_out[p] = gen_reg_sel[p] ? path_q[p] : path_comb[p];
      end
   endgenerate

   // Outputs held low during a configuration load
   assign comb_o    = prog_en ? '0 : path_comb;
   assign q_o       = prog_en ? '0 : path_q;
   assign out_o     = prog_en ? '0 : path_out;
   assign carry_out = ~prog_en & carry_w[NG];
endmodule

// File: rtl/slice_chk.sv
module slice_chk
   import slice_pkg::*;
#(
   parameter int LUT_IN = 4
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           prog_en,
   input logic                           we,
   input logic                           ce,
   input logic [LUT_IN-1:0]              ina,
   input logic [LUT_IN-1:0]              inb,
   input logic [1:0]                     din,
   input logic [1:0]                     comb_o,
   input logic [1:0]                     q_o,
   input logic [1:0][(1<<LUT_IN)-1:0]    gen_content,
   input logic [1:0][1:0]                gen_mode,
   input logic [1:0]                     gen_reg_sel,
   input logic [1:0]                     gen_latch
);
   localparam int DEPTH = 1 << LUT_IN;

   logic [1:0][LUT_IN-1:0] addr_w;
   assign addr_w[0] = ina;
   assign addr_w[1] = inb;

   // R1
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !prog_en |=> ($stable(gen_mode) && $stable(gen_reg_sel) && $stable(gen_latch)));

   // R11
   rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (q_o == 2'b00));

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_chk
         // R4
         ram_write_chk: assert property (@(posedge clk) disable iff (rst)
            (!prog_en && we && gen_mode[g] == FG_RAM)
            |=> (gen_content[g][$past(addr_w[g])] == $past(din[g])));

         // R5
         shift_step_chk: assert property (@(posedge clk) disable iff (rst)
            (!prog_en && we && gen_mode[g] == FG_SHIFT)
            |=> (gen_content[g][0] == $past(din[g]) &&
                 gen_content[g][DEPTH-1:1] == $past(gen_content[g][DEPTH-2:0])));

         // R9
         ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
            (!prog_en && ce && !gen_latch[g])
            |=> (prog_en || q_o[g] == $past(comb_o[g])));
      end
   endgenerate
endmodule

bind lut_slice slice_chk #(.LUT_IN(LUT_IN)) i_chk (
   .clk         (clk),
   .rst         (rst),
   .prog_en     (prog_en),
   .we          (we),
   .ce          (ce),
   .ina         (ina),
   .inb         (inb),
   .din         (din),
   .comb_o      (comb_o),
   .q_o         (q_o),
   .gen_content (gen_content),
   .gen_mode    (gen_mode),
   .gen_reg_sel (gen_reg_sel),
   .gen_latch   (gen_latch)
);

// File: tb/test_lut_slice.sv
module test_lut_slice;
   localparam int CLK_PERIOD = 10;
   localparam int CFG_W      = 43;

   logic       clk = 1'b0;
   logic       rst, prog_en, cfg_in, sel5, carry_in, ce, we;
   logic [3:0] ina, inb;
   logic [1:0] din, comb_o, q_o, out_o;
   logic       carry_out;

   int total = 0;
   int bad   = 0;

   // Model state
   logic [15:0] mc [2];
   logic [1:0]  mmode [2];
   logic        mreg [2];
   logic        mlat [2];
   logic        mari [2];
   logic        mwide;
   logic [1:0]  mq;

   lut_slice i_lut_slice (
      .clk(clk), .rst(rst), .prog_en(prog_en), .cfg_in(cfg_in),
      .ina(ina), .inb(inb), .sel5(sel5), .din(din), .carry_in(carry_in),
      .ce(ce), .we(we), .comb_o(comb_o), .q_o(q_o), .out_o(out_o),
      .carry_out(carry_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [20:0] mk_seg(int g);
      return {mari[g], mlat[g], mreg[g], mmode[g], mc[g]};
   endfunction

   // Expected combinational outputs and carry from the model
   task automatic compute(output logic [1:0] ec, output logic eco);
      logic l0, l1, c0, r0, r1;
      l0 = mc[0][ina];
      l1 = mc[1][inb];
      c0 = l0 ? carry_in : ina[0];
      r0 = mari[0] ? (l0 ^ carry_in) : l0;
      r1 = mari[1] ? (l1 ^ c0) : l1;
      ec[0] = r0;
      ec[1] = mwide ? (sel5 ? l1 : l0) : r1;
      eco = l1 ? c0 : inb[0];
   endtask

   task automatic load_cfg();
      logic [CFG_W-1:0] w;
      logic zero_ok;
      w = {mk_seg(1), mk_seg(0), mwide};
      zero_ok = 1'b1;
      for (int i = 0; i < CFG_W; i++) begin
         @(negedge clk);
         prog_en = 1'b1;
         cfg_in  = w[i];
         we      = 1'($urandom);
         ce      = 1'($urandom);
         din     = 2'($urandom);
         #1;
         if (comb_o !== 2'b00 || q_o !== 2'b00 || out_o !== 2'b00 || carry_out !== 1'b0)
            zero_ok = 1'b0;
      end
      @(negedge clk);
      prog_en = 1'b0;
      cfg_in  = 1'b0;
      we      = 1'b0;
      ce      = 1'b0;
      #1;
      check("R2 outputs held low during load", 32'(zero_ok), 32'd1);
   endtask

   task automatic pulse_rst();
      @(negedge clk);
      rst = 1'b1;
      we  = 1'b0;
      ce  = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      mq  = 2'b00;
   endtask

   task automatic set_all(logic [1:0] mode, logic rs, logic lt, logic ar, logic wide);
      for (int g = 0; g < 2; g++) begin
         mc[g]    = 16'($urandom);
         mmode[g] = mode;
         mreg[g]  = rs;
         mlat[g]  = lt;
         mari[g]  = ar;
      end
      mwide = wide;
   endtask

   task automatic rand_in();
      ina      = 4'($urandom);
      inb      = 4'($urandom);
      sel5     = 1'($urandom);
      carry_in = 1'($urandom);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [1:0] ec, qexp;
      logic       eco;
      void'($urandom(32'h5eed_1234));
      rst = 1'b1; prog_en = 1'b0; cfg_in = 1'b0; sel5 = 1'b0; carry_in = 1'b0;
      ce = 1'b0; we = 1'b0; ina = '0; inb = '0; din = '0; mq = '0;
      repeat (3) @(negedge clk);
      #1;
      check("R11 storage clear after reset", 32'(q_o), 32'd0);
      rst = 1'b0;

      // Truth mode, registered paths off (R3, R8, R1)
      set_all(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      mmode[1] = 2'd3;
      load_cfg();
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         rand_in();
         we  = 1'($urandom);
         din = 2'($urandom);
         if (i == 0) begin ina = 4'd0; inb = 4'd15; end
         if (i == 1) begin ina = 4'd15; inb = 4'd0; end
         #1;
         compute(ec, eco);
         check("R3 truth lookup", 32'(comb_o), 32'(ec));
         check("R8 comb path select", 32'(out_o), 32'(ec));
      end

      // Combining mux (R7)
      set_all(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      load_cfg();
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         rand_in();
         sel5 = i[0];
         #1;
         check("R7 wide mux", 32'(comb_o[1]), 32'(sel5 ? mc[1][inb] : mc[0][ina]));
      end

      // Two-bit ripple adder (R6)
      set_all(2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      mc[0] = 16'h6666;
      mc[1] = 16'h6666;
      load_cfg();
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            for (int ci = 0; ci < 2; ci++) begin
               @(negedge clk);
               ina      = {2'($urandom), b[0], a[0]};
               inb      = {2'($urandom), b[1], a[1]};
               carry_in = ci[0];
               #1;
               check("R6 adder sum/carry", 32'({carry_out, comb_o}), 32'(a + b + ci));
            end
         end
      end

      // RAM mode (R4), then reset keeps contents (R11)
      set_all(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
      load_cfg();
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         rand_in();
         we  = 1'($urandom);
         din = 2'($urandom);
         #1;
         compute(ec, eco);
         check("R4 ram read", 32'(comb_o), 32'(ec));
         if (we) begin
            mc[0][ina] = din[0];
            mc[1][inb] = din[1];
         end
      end
      pulse_rst();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rand_in();
         #1;
         compute(ec, eco);
         check("R11 contents kept over reset", 32'(comb_o), 32'(ec));
         check("R11 storage cleared", 32'(q_o), 32'd0);
      end

      // Shift-register mode (R5)
      set_all(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
      load_cfg();
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         rand_in();
         if (i == 2) begin ina = 4'd0; inb = 4'd15; end
         we  = 1'($urandom);
         din = 2'($urandom);
         #1;
         compute(ec, eco);
         check("R5 shift tap", 32'(comb_o), 32'(ec));
         if (we) begin
            mc[0] = {mc[0][14:0], din[0]};
            mc[1] = {mc[1][14:0], din[1]};
         end
      end

      // Flip-flop storage (R9, R8)
      set_all(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
      load_cfg();
      pulse_rst();
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         rand_in();
         ce = 1'($urandom);
         we = 1'($urandom);
         #1;
         compute(ec, eco);
         check("R9 flip-flop output", 32'(out_o), 32'(mq));
         check("R1 table unchanged in truth mode", 32'(comb_o), 32'(ec));
         if (ce) mq = ec;
      end
      pulse_rst();
      #1;
      check("R11 flip-flops cleared", 32'(q_o), 32'd0);

      // Latch storage (R10)
      set_all(2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
      load_cfg();
      pulse_rst();
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         rand_in();
         ce = 1'($urandom);
         #1;
         check("R10 latch holds while clock low", 32'(q_o), 32'(mq));
         compute(ec, eco);
         @(posedge clk);
         #1;
         if (ce) mq = ec;
         check("R10 latch while clock high", 32'(out_o), 32'(mq));
      end

      // Same-edge RAM write and flip-flop capture (R12)
      set_all(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
      load_cfg();
      pulse_rst();
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         rand_in();
         din = ~{mc[1][inb], mc[0][ina]};
         we  = 1'b1;
         ce  = 1'b1;
         #1;
         compute(ec, eco);
         qexp = ec;
         mc[0][ina] = din[0];
         mc[1][inb] = din[1];
         @(negedge clk);
         we = 1'b0;
         ce = 1'b0;
         #1;
         compute(ec, eco);
         check("R12 capture takes old word", 32'(q_o), 32'(qexp));
         check("R12 read shows new word", 32'(comb_o), 32'(ec));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule